// File: doc/BRIEF.md
# Memory-Mapped 64-bit Machine Timer

This peripheral keeps a 64-bit time value and compares it against a 64-bit deadline. The time value advances only while the timer is active. A tick divider counts clock cycles up to a programmable prescale limit, and on each wrap the time value grows by a programmable step. When the deadline is less than or equal to the time value, the block asserts a raw machine-timer line. That line does not depend on any enable. It also sets a sticky status bit that drives a peripheral interrupt, but only when the interrupt is enabled.

Software reaches the block through a simple 32-bit register port. A request presents a byte address, a write flag and write data. A read returns its data combinationally in the same cycle, and a write takes effect at the next rising clock edge. Every register is one full word. Software can set the time, move the deadline, clear the status bit by writing a 1 to it, and inject a test interrupt.

Top module: `mmio_mtimer`

## Requirements
- R1: After reset the registers read as follows: control 0, configuration 0x00010000 (prescale 0, step 1), both deadline halves 0xFFFFFFFF, enable 0, status 0 and test 0. The `mtip_o` and `irq_o` outputs are both low.
- R2: The byte offsets are: control 0x000 (bit 0 is the active flag), configuration 0x100 (prescale in bits 11:0, step in bits 23:16), time low 0x104, time high 0x108, deadline low 0x10C, deadline high 0x110, enable 0x114 (bit 0), status 0x118 (bit 0), test 0x11C (bit 0). Unused bits read as zero.
- R3: While the timer is active, the time value grows by the step once every prescale+1 clock edges. The first growth comes prescale+1 edges after the edge that sets the active flag. While the timer is inactive, the time value holds and the tick divider restarts from zero.
- R4: A write to the time low word replaces only bits 31:0, and a write to the time high word replaces only bits 63:32. If such a write lands on the same edge as a tick, the write wins and that tick's growth is dropped.
- R5: The time value is a full 64-bit count, so growth carries from bit 31 into bit 32.
- R6: While the timer is active, `mtip_o` follows the condition (deadline <= time value), one edge after that condition holds, whatever the enable bit says. While the timer is inactive, `mtip_o` keeps its last value.
- R7: A firing condition sets status bit 0, and with it `irq_o`, only while enable bit 0 is 1.
- R8: Writing status with bit 0 set clears status bit 0 and `irq_o`. If a set request (from firing or from the test register) occurs on the same edge, the set wins.
- R9: A write to either deadline half that moves the deadline past the time value, while the timer is active, drops `mtip_o` and `irq_o` on the next edge. Status bit 0 keeps its value.
- R10: Writing the test register with bit 0 set sets status bit 0 and `irq_o` on the same edge, but only when enable bit 0 is already 1. The test bit reads back as written.
- R11: Reads of unmapped offsets, or of any address whose two low bits are not zero, return 0, and writes to them change nothing.
- R12: `irq_o` is never high while status bit 0 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 10 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the same cycle as the request |
| mtip_o | output | 1 | Raw machine-timer line, not gated by the enable |
| irq_o | output | 1 | Peripheral interrupt, gated by the enable and sticky |

## Verification
Two functions can act on status bit 0 on the same edge: a clear by writing 1, and a set from a firing condition that still holds. The bench lets the deadline fall behind the time value with the enable on, then writes 1 to status and reads it back; the bit must still be 1 and `irq_o` must stay high. It repeats the clear with the enable off and expects 0 on both, while `mtip_o` stays high. A second collision writes the time low word on an edge where a tick also lands; the read-back must show only the written value plus the later tick.

// File: rtl/mtm_pkg.sv
package mtm_pkg;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int TIME_W = 64;
  localparam int CFG_STEP_LSB = 16;

  localparam logic [ADDR_W-1:0] OFF_CTRL   = 10'h000;
  localparam logic [ADDR_W-1:0] OFF_CFG    = 10'h100;
  localparam logic [ADDR_W-1:0] OFF_TIME_L = 10'h104;
  localparam logic [ADDR_W-1:0] OFF_TIME_H = 10'h108;
  localparam logic [ADDR_W-1:0] OFF_DL_L   = 10'h10C;
  localparam logic [ADDR_W-1:0] OFF_DL_H   = 10'h110;
  localparam logic [ADDR_W-1:0] OFF_EN     = 10'h114;
  localparam logic [ADDR_W-1:0] OFF_STAT   = 10'h118;
  localparam logic [ADDR_W-1:0] OFF_TEST   = 10'h11C;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CTRL, SEL_CFG, SEL_TIME_L, SEL_TIME_H,
    SEL_DL_L, SEL_DL_H, SEL_EN, SEL_STAT, SEL_TEST
  } reg_sel_e;

  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    if (a[1:0] != 2'b00) return SEL_NONE;
    case (a)
      OFF_CTRL:   return SEL_CTRL;
      OFF_CFG:    return SEL_CFG;
      OFF_TIME_L: return SEL_TIME_L;
      OFF_TIME_H: return SEL_TIME_H;
      OFF_DL_L:   return SEL_DL_L;
      OFF_DL_H:   return SEL_DL_H;
      OFF_EN:     return SEL_EN;
      OFF_STAT:   return SEL_STAT;
      OFF_TEST:   return SEL_TEST;
      default:    return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/mtm_regs.sv
module mtm_regs
  import mtm_pkg::*;
#(
  parameter int PRESCALE_W = 12,
  parameter int STEP_W     = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  input  logic [TIME_W-1:0]     time_i,
  input  logic                  stat_i,
  output logic                  active_o,
  output logic [PRESCALE_W-1:0] prescale_o,
  output logic [STEP_W-1:0]     step_o,
  output logic [TIME_W-1:0]     deadline_o,
  output logic                  en_o,
  output logic                  time_wr_l_o,
  output logic                  time_wr_h_o,
  output logic                  dl_wr_o,
  output logic                  stat_clr_o,
  output logic                  test_req_o
);
  localparam int HALF = TIME_W / 2;

  reg_sel_e sel;
  logic     wr;
  logic     active_q, en_q, test_q;
  logic [PRESCALE_W-1:0] prescale_q;
  logic [STEP_W-1:0]     step_q;
  logic [TIME_W-1:0]     dl_q;

  assign sel = decode(addr_i);
  assign wr  = req_i & we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      prescale_q <= '0;
      step_q     <= STEP_W'(1);
      dl_q       <= '1;
      en_q       <= 1'b0;
      test_q     <= 1'b0;
    end else if (wr) begin
      case (sel)
        SEL_CTRL: active_q <= wdata_i[0];
        SEL_CFG: begin
          prescale_q <= wdata_i[PRESCALE_W-1:0];
          step_q     <= wdata_i[CFG_STEP_LSB +: STEP_W];
        end
        SEL_DL_L: dl_q[HALF-1:0]      <= wdata_i;
        SEL_DL_H: dl_q[TIME_W-1:HALF] <= wdata_i;
        SEL_EN:   en_q   <= wdata_i[0];
        SEL_TEST: test_q <= wdata_i[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      case (sel)
        SEL_CTRL:   rdata_o[0] = active_q;
        SEL_CFG: begin
          rdata_o[PRESCALE_W-1:0]          = prescale_q;
          rdata_o[CFG_STEP_LSB +: STEP_W]  = step_q;
        end
        SEL_TIME_L: rdata_o = time_i[HALF-1:0];
        SEL_TIME_H: rdata_o = time_i[TIME_W-1:HALF];
        SEL_DL_L:   rdata_o = dl_q[HALF-1:0];
        SEL_DL_H:   rdata_o = dl_q[TIME_W-1:HALF];
        SEL_EN:     rdata_o[0] = en_q;
        SEL_STAT:   rdata_o[0] = stat_i;
        SEL_TEST:   rdata_o[0] = test_q;
        default:    rdata_o = '0;
      endcase
    end
  end

  assign active_o    = active_q;
  assign prescale_o  = prescale_q;
  assign step_o      = step_q;
  assign deadline_o  = dl_q;
  assign en_o        = en_q;
  assign time_wr_l_o = wr && (sel == SEL_TIME_L);
  assign time_wr_h_o = wr && (sel == SEL_TIME_H);
  assign dl_wr_o     = wr && ((sel == SEL_DL_L) || (sel == SEL_DL_H));
  assign stat_clr_o  = wr && (sel == SEL_STAT) && wdata_i[0];
  assign test_req_o  = wr && (sel == SEL_TEST) && wdata_i[0];

  a_r11_unmapped_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i[1:0] != 2'b00) |-> (rdata_o == '0));
  a_r2_deadline_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dl_wr_o |=> $stable(dl_q));
endmodule

// File: rtl/mtm_count.sv
module mtm_count
  import mtm_pkg::*;
#(
  parameter int PRESCALE_W = 12,
  parameter int STEP_W     = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  active_i,
  input  logic [PRESCALE_W-1:0] prescale_i,
  input  logic [STEP_W-1:0]     step_i,
  input  logic                  wr_l_i,
  input  logic                  wr_h_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [TIME_W-1:0]     time_o
);
  localparam int HALF = TIME_W / 2;

  logic [PRESCALE_W-1:0] div_q;
  logic [TIME_W-1:0]     time_q;
  logic                  tick;

  // >= so that lowering the prescale mid-count still wraps
  assign tick = active_i && (div_q >= prescale_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        div_q <= '0;
    else if (!active_i) div_q <= '0;
    else if (tick)      div_q <= '0;
    else                div_q <= div_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     time_q <= '0;
    else if (wr_l_i) time_q <= {time_q[TIME_W-1:HALF], wdata_i};
    else if (wr_h_i) time_q <= {wdata_i, time_q[HALF-1:0]};
    else if (tick)   time_q <= time_q + TIME_W'(step_i);
  end

  assign time_o = time_q;

  a_r3_hold_inactive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_i && !wr_l_i && !wr_h_i) |=> $stable(time_q));
  a_r3_div_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (div_q == '0));
  a_r4_low_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_l_i |=> (time_q[HALF-1:0] == $past(wdata_i)));
  a_r4_high_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_h_i |=> (time_q[TIME_W-1:HALF] == $past(wdata_i)));
endmodule

// File: rtl/mtm_irq.sv
module mtm_irq
  import mtm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic [TIME_W-1:0] deadline_i,
  input  logic              dl_wr_i,
  input  logic              en_i,
  input  logic              clr_i,
  input  logic              test_i,
  output logic              mtip_o,
  output logic              stat_o,
  output logic              irq_o
);
  logic fire, set, dl_wr_q;
  logic mtip_q, stat_q, irq_q;

  assign fire = deadline_i <= time_i;
  assign set  = en_i && ((active_i && fire) || test_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mtip_q  <= 1'b0;
      stat_q  <= 1'b0;
      irq_q   <= 1'b0;
      dl_wr_q <= 1'b0;
    end else begin
      dl_wr_q <= dl_wr_i;
      if (active_i) mtip_q <= fire;
      stat_q <= set | (stat_q & ~clr_i);
      if (set)                                irq_q <= 1'b1;
      else if (clr_i)                         irq_q <= 1'b0;
      else if (active_i && dl_wr_q && !fire)  irq_q <= 1'b0;
    end
  end

  assign mtip_o = mtip_q;
  assign stat_o = stat_q;
  assign irq_o  = irq_q;

  a_r12_irq_needs_stat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> stat_q);
  a_r8_stat_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q && !clr_i) |=> stat_q);
  a_r7_no_set_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !stat_q) |=> !stat_q);
  a_r6_hold_inactive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> $stable(mtip_q));
  a_r9_future_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && dl_wr_q && !fire && !test_i) |=> (!mtip_q && !irq_q));
endmodule

// File: rtl/mmio_mtimer.sv
module mmio_mtimer
  import mtm_pkg::*;
#(
  parameter int PRESCALE_W = 12,
  parameter int STEP_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mtip_o,
  output logic              irq_o
);
  logic                  active, en, stat;
  logic                  time_wr_l, time_wr_h, dl_wr, stat_clr, test_req;
  logic [PRESCALE_W-1:0] prescale;
  logic [STEP_W-1:0]     step;
  logic [TIME_W-1:0]     time_val, deadline;

  mtm_regs #(.PRESCALE_W(PRESCALE_W), .STEP_W(STEP_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .time_i(time_val), .stat_i(stat),
    .active_o(active), .prescale_o(prescale), .step_o(step),
    .deadline_o(deadline), .en_o(en),
    .time_wr_l_o(time_wr_l), .time_wr_h_o(time_wr_h), .dl_wr_o(dl_wr),
    .stat_clr_o(stat_clr), .test_req_o(test_req)
  );

  mtm_count #(.PRESCALE_W(PRESCALE_W), .STEP_W(STEP_W)) u_count (
    .clk_i, .rst_ni, .active_i(active), .prescale_i(prescale), .step_i(step),
    .wr_l_i(time_wr_l), .wr_h_i(time_wr_h), .wdata_i, .time_o(time_val)
  );

  mtm_irq u_irq (
    .clk_i, .rst_ni, .active_i(active), .time_i(time_val), .deadline_i(deadline),
    .dl_wr_i(dl_wr), .en_i(en), .clr_i(stat_clr), .test_i(test_req),
    .mtip_o, .stat_o(stat), .irq_o
  );
endmodule

// File: tb/sim_mmio_mtimer.sv
`timescale 1ns/1ps
module sim_mmio_mtimer;
  localparam logic [9:0] A_CTRL = 10'h000, A_CFG = 10'h100, A_TL = 10'h104,
    A_TH = 10'h108, A_DL = 10'h10C, A_DH = 10'h110, A_EN = 10'h114,
    A_ST = 10'h118, A_TS = 10'h11C;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        mtip, irq;
  int          n_run = 0, n_fail = 0;
  logic        done = 1'b0;

  always #2.5 clk = ~clk;

  mmio_mtimer u0 (.clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .mtip_o(mtip), .irq_o(irq));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  // called at a negedge; the write commits at the next posedge
  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 mtip", {31'b0, mtip}, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_CFG, v);  chk("R1 cfg", v, 32'h0001_0000);
    rd(A_DL, v);   chk("R1 deadline low", v, 32'hFFFF_FFFF);
    rd(A_DH, v);   chk("R1 deadline high", v, 32'hFFFF_FFFF);
    rd(A_EN, v);   chk("R1 enable", v, 0);
    rd(A_ST, v);   chk("R1 status", v, 0);
    rd(A_TS, v);   chk("R1 test", v, 0);
  endtask

  task automatic t_map;
    logic [31:0] v;
    wr(10'h004, 32'hFFFF_FFFF);
    rd(10'h004, v); chk("R11 unmapped read", v, 0);
    wr(10'h101, 32'h0000_0000);
    rd(A_CFG, v);   chk("R11 misaligned write ignored", v, 32'h0001_0000);
    rd(10'h120, v); chk("R11 beyond map", v, 0);
    wr(A_CFG, 32'hFFFF_FFFF);
    rd(A_CFG, v);   chk("R2 cfg fields", v, 32'h00FF_0FFF);
    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_EN, v);    chk("R2 enable bit0", v, 1);
    wr(A_EN, 0);
  endtask

  task automatic t_count;
    logic [31:0] v;
    wr(A_TL, 0); wr(A_TH, 0);
    wr(A_CFG, (32'd5 << 16) | 32'd3);
    wr(A_CTRL, 1);
    idle(11);
    wr(A_CTRL, 0);           // 12 active edges, prescale 3 -> 3 ticks of 5
    rd(A_TL, v); chk("R3 prescaled count", v, 15);
    idle(5);
    rd(A_TL, v); chk("R3 hold while inactive", v, 15);
  endtask

  task automatic t_halves;
    logic [31:0] v;
    wr(A_TL, 32'h1234_5678);
    wr(A_TH, 32'h0000_00AB);
    rd(A_TL, v); chk("R4 low write", v, 32'h1234_5678);
    rd(A_TH, v); chk("R4 high write", v, 32'h0000_00AB);
    wr(A_CFG, 32'h0001_0000);
    wr(A_CTRL, 1);
    wr(A_TL, 32'h100);       // lands on a tick edge
    wr(A_CTRL, 0);           // one more tick on this edge
    rd(A_TL, v); chk("R4 write beats tick", v, 32'h101);
    rd(A_TH, v); chk("R4 high untouched", v, 32'hAB);
  endtask

  task automatic t_carry;
    logic [31:0] v;
    wr(A_TL, 32'hFFFF_FFFE); wr(A_TH, 0);
    wr(A_CTRL, 1);
    idle(2);
    wr(A_CTRL, 0);           // 3 ticks of 1
    rd(A_TL, v); chk("R5 carry low", v, 1);
    rd(A_TH, v); chk("R5 carry high", v, 1);
  endtask

  task automatic t_fire;
    logic [31:0] v;
    wr(A_DH, 1); wr(A_DL, 0);  // deadline 0x1_00000000 <= time 0x1_00000001
    idle(2);
    chk("R6 no evaluation while inactive", {31'b0, mtip}, 0);
    wr(A_CTRL, 1);
    idle(2);
    chk("R6 raw line fires", {31'b0, mtip}, 1);
    chk("R7 no irq without enable", {31'b0, irq}, 0);
    rd(A_ST, v); chk("R7 status stays clear", v, 0);
    wr(A_EN, 1);
    idle(1);
    chk("R7 irq with enable", {31'b0, irq}, 1);
    rd(A_ST, v); chk("R7 status set", v, 1);
    wr(A_ST, 1);             // clear collides with ongoing set
    rd(A_ST, v); chk("R8 set wins over clear", v, 1);
    chk("R8 irq kept", {31'b0, irq}, 1);
    wr(A_EN, 0);
    wr(A_ST, 1);
    rd(A_ST, v); chk("R8 write-1 clears", v, 0);
    chk("R8 irq cleared", {31'b0, irq}, 0);
    chk("R6 raw line ignores enable", {31'b0, mtip}, 1);
    wr(A_EN, 1);
    idle(1);
    wr(A_DH, 32'h0000_FFFF);   // move deadline into the future
    idle(1);
    chk("R9 raw line drops", {31'b0, mtip}, 0);
    chk("R9 irq drops", {31'b0, irq}, 0);
    rd(A_ST, v); chk("R9 status kept", v, 1);
    chk("R12 irq low with status after drop", {31'b0, irq}, 0);
    wr(A_CTRL, 0);
  endtask

  task automatic t_test;
    logic [31:0] v;
    wr(A_ST, 1);
    wr(A_EN, 0);
    wr(A_TS, 1);
    rd(A_ST, v); chk("R10 test gated by enable", v, 0);
    chk("R10 no irq when gated", {31'b0, irq}, 0);
    rd(A_TS, v); chk("R10 test readback", v, 1);
    wr(A_EN, 1);
    wr(A_TS, 1);
    chk("R10 irq from test", {31'b0, irq}, 1);
    rd(A_ST, v); chk("R10 status from test", v, 1);
    wr(A_ST, 1);
    chk("R12 irq follows clear", {31'b0, irq}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_count();
    t_halves();
    t_carry();
    t_fire();
    t_test();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule